// File: doc/BRIEF.md
# Disk Sector Sequencer with Deleted-Mark Skip

This block follows the position of a multi-sector data read on a floppy-style disk controller. A command start loads the starting cylinder, head and sector, the last sector number of the track, a multi-track enable, a skip enable and the kind of data mark the read is looking for (deleted or normal). After that, a sector engine reports one event per sector it has found. Each event carries the mark kind of that sector and an optional "last" flag meaning the host wants no more data.

For every accepted event the block decides whether the sector's data goes to the host or is skipped. It raises the sticky control-mark status bit when the mark differs from the wanted kind. It then moves the position on to the next sector, wrapping at the end of the track onto the second head or the next cylinder. When the read ends, it pulses `done`. At that point the result cylinder, head and sector and a termination code are ready for the result phase.

A mark mismatch with skip disabled ends the read once that sector has been transferred. With skip enabled, the mismatched sector is passed over and sequencing goes on.

Top module: `dss_top`

## Requirements
- R1: One cycle after `cmd_start`, `busy` is 1, `done` is 0, `ctrl_mark` is 0 and `res_cyl`/`res_head`/`res_sec` equal the command's start values; a start while busy restarts the read.
- R2: An accepted event on a sector other than the end-of-track sector leaves cylinder and head unchanged and advances the sector by one, for every multi-track and head combination.
- R3: With `cmd_mt`=0, an accepted event on the end-of-track sector gives sector 1, the same head and cylinder plus one (modulo 2^CYL_W), and ends the read.
- R4: With `cmd_mt`=1 on head 0, an accepted event on the end-of-track sector gives sector 1, head 1 and the same cylinder, and the read continues (`busy` stays 1, no `done`).
- R5: With `cmd_mt`=1 on head 1, an accepted event on the end-of-track sector gives sector 1, head 0 and cylinder plus one, and ends the read.
- R6: A sector whose mark matches the wanted kind produces one `xfer_pulse`, no `skip_pulse`, and leaves `ctrl_mark` unchanged.
- R7: A mismatched mark with `cmd_sk`=0 produces `xfer_pulse`, sets `ctrl_mark`, and ends the read with `term_code`=1 and the position advanced past that sector.
- R8: A mismatched mark with `cmd_sk`=1 produces `skip_pulse` without `xfer_pulse`, sets `ctrl_mark`, and continues; a read in which any sector was skipped ends with `term_code`=2.
- R9: `sec_last`=1 on an accepted event ends the read after that sector; a read that ends without a mark stop and without skips reports `term_code`=0; `done` is a single-cycle pulse coinciding with `busy` falling.
- R10: Sector events while not busy have no effect: no pulses, no `done`, and the result position stays unchanged.
- R11: `cmd_want_del`=1 makes a deleted mark (`sec_del_mark`=1) the matching kind; `cmd_want_del`=0 makes a normal mark the matching kind.
- R12: During and after reset, `busy`, `done`, `xfer_pulse`, `skip_pulse`, `ctrl_mark`, `term_code` and the result position are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Load command parameters and begin a read |
| cmd_cyl | input | CYL_W | Starting cylinder |
| cmd_head | input | 1 | Starting head |
| cmd_sec | input | SEC_W | Starting sector |
| cmd_eot | input | SEC_W | Last sector number on the track |
| cmd_mt | input | 1 | Multi-track enable |
| cmd_sk | input | 1 | Skip mismatched sectors instead of stopping |
| cmd_want_del | input | 1 | 1: deleted-data read, 0: normal-data read |
| sec_evt | input | 1 | One-cycle sector-found event |
| sec_del_mark | input | 1 | Mark of the found sector, 1 = deleted |
| sec_last | input | 1 | Host wants no more sectors after this one |
| busy | output | 1 | A read is in progress |
| xfer_pulse | output | 1 | The sector just handled was transferred |
| skip_pulse | output | 1 | The sector just handled was skipped |
| ctrl_mark | output | 1 | Sticky control-mark status bit |
| done | output | 1 | One-cycle end-of-read pulse |
| res_cyl | output | CYL_W | Current / result cylinder |
| res_head | output | 1 | Current / result head |
| res_sec | output | SEC_W | Current / result sector |
| term_code | output | 2 | 0 normal, 1 mark stop, 2 ended after skips |

## Verification
A corrupted position register shows on `res_cyl`/`res_head`/`res_sec` in the cycle after the event that wrote it. A wrong end-of-track or head-flip decision also flips `busy` and `done` in that same cycle. A stale skip or mark flag stays hidden until the read ends, and then appears as a wrong `term_code` on the `done` pulse. For that reason the bench checks every field after every event, and it checks the termination code on every completion.

// File: rtl/dss_pkg.sv
package dss_pkg;
   typedef enum logic [1:0] {
      TERM_NORMAL    = 2'd0,
      TERM_MARK_STOP = 2'd1,
      TERM_SKIP_END  = 2'd2
   } term_e;

   typedef struct packed {
      logic mismatch;
      logic xfer;
      logic skip;
      logic stop_now;
   } verdict_t;
endpackage

// File: rtl/dss_advance.sv
// Next-position arithmetic: sector step, head flip, cylinder step.
module dss_advance #(
   parameter int CYL_W     = 8,
   parameter int SEC_W     = 8,
   parameter int FIRST_SEC = 1,
   parameter bit MT_ENABLE = 1'b1
) (
   input  logic [CYL_W-1:0] cyl_i,
   input  logic             head_i,
   input  logic [SEC_W-1:0] sec_i,
   input  logic [SEC_W-1:0] eot_i,
   input  logic             mt_i,
   output logic [CYL_W-1:0] cyl_o,
   output logic             head_o,
   output logic [SEC_W-1:0] sec_o,
   output logic             track_done_o
);
   localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(FIRST_SEC);

   logic mt_eff;
   logic at_eot;
   logic flip_head;

   generate
      if (MT_ENABLE) begin : g_mt
         assign mt_eff = mt_i;
      end else begin : g_single
         assign mt_eff = 1'b0;
      end
   endgenerate

   assign at_eot    = (sec_i == eot_i);
   assign flip_head = mt_eff & ~head_i;

   always_comb begin
      cyl_o  = cyl_i;
      head_o = head_i;
      sec_o  = sec_i + SEC_W'(1);
      if (at_eot) begin
         sec_o = SEC_ONE;
         if (flip_head) begin
            head_o = 1'b1;
         end else begin
            cyl_o = cyl_i + CYL_W'(1);
            if (mt_eff) head_o = 1'b0;
         end
      end
   end

   assign track_done_o = at_eot & ~flip_head;
endmodule

// File: rtl/dss_judge.sv
// Mark comparison and transfer/skip/stop verdict for one sector.
module dss_judge
   import dss_pkg::*;
(
   input  logic     want_del_i,
   input  logic     mark_del_i,
   input  logic     skip_en_i,
   output verdict_t verdict_o
);
   always_comb begin
      verdict_o.mismatch = want_del_i ^ mark_del_i;
      verdict_o.skip     = verdict_o.mismatch & skip_en_i;
      verdict_o.xfer     = ~verdict_o.skip;
      verdict_o.stop_now = verdict_o.mismatch & ~skip_en_i;
   end
endmodule

// File: rtl/dss_ctrl.sv
// Run state, status flags, pulses and termination code.
module dss_ctrl
   import dss_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  logic     evt_i,
   input  verdict_t verdict_i,
   input  logic     track_done_i,
   input  logic     last_i,
   output logic     accept_o,
   output logic     busy_o,
   output logic     xfer_o,
   output logic     skip_o,
   output logic     mark_o,
   output logic     done_o,
   output term_e    term_o
);
   logic  busy_q, xfer_q, skip_q, mark_q, done_q, skipped_q;
   term_e term_q;
   logic  finish;

   assign accept_o = evt_i & busy_q & ~start_i;
   assign finish   = accept_o & (verdict_i.stop_now | track_done_i | last_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         xfer_q    <= 1'b0;
         skip_q    <= 1'b0;
         mark_q    <= 1'b0;
         done_q    <= 1'b0;
         skipped_q <= 1'b0;
         term_q    <= TERM_NORMAL;
      end else begin
         xfer_q <= accept_o & verdict_i.xfer;
         skip_q <= accept_o & verdict_i.skip;
         done_q <= finish;
         if (start_i) begin
            busy_q    <= 1'b1;
            mark_q    <= 1'b0;
            skipped_q <= 1'b0;
            term_q    <= TERM_NORMAL;
         end else if (accept_o) begin
            if (verdict_i.mismatch) mark_q <= 1'b1;
            if (verdict_i.skip) skipped_q <= 1'b1;
            if (finish) begin
               busy_q <= 1'b0;
               if (verdict_i.stop_now)
                  term_q <= TERM_MARK_STOP;
               else if (skipped_q | verdict_i.skip)
                  term_q <= TERM_SKIP_END;
               else
                  term_q <= TERM_NORMAL;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign xfer_o = xfer_q;
   assign skip_o = skip_q;
   assign mark_o = mark_q;
   assign done_o = done_q;
   assign term_o = term_q;
endmodule

// File: rtl/dss_top.sv
module dss_top
   import dss_pkg::*;
#(
   parameter int CYL_W     = 8,
   parameter int SEC_W     = 8,
   parameter int FIRST_SEC = 1,
   parameter bit MT_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic [CYL_W-1:0] cmd_cyl,
   input  logic             cmd_head,
   input  logic [SEC_W-1:0] cmd_sec,
   input  logic [SEC_W-1:0] cmd_eot,
   input  logic             cmd_mt,
   input  logic             cmd_sk,
   input  logic             cmd_want_del,
   input  logic             sec_evt,
   input  logic             sec_del_mark,
   input  logic             sec_last,
   output logic             busy,
   output logic             xfer_pulse,
   output logic             skip_pulse,
   output logic             ctrl_mark,
   output logic             done,
   output logic [CYL_W-1:0] res_cyl,
   output logic             res_head,
   output logic [SEC_W-1:0] res_sec,
   output logic [1:0]       term_code
);
   generate
      if (CYL_W < 1) begin : g_bad_cyl
         $error("dss_top: CYL_W must be at least 1");
      end
      if (SEC_W < 2) begin : g_bad_sec
         $error("dss_top: SEC_W must be at least 2");
      end
      if (FIRST_SEC < 0 || FIRST_SEC >= (1 << SEC_W)) begin : g_bad_first
         $error("dss_top: FIRST_SEC does not fit in SEC_W bits");
      end
   endgenerate

   logic [CYL_W-1:0] cyl_q, cyl_n;
   logic             head_q, head_n;
   logic [SEC_W-1:0] sec_q, sec_n;
   logic [SEC_W-1:0] eot_q;
   logic             mt_q, sk_q, want_q;
   logic             track_done;
   logic             accept;
   verdict_t         verdict;
   term_e            term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyl_q  <= '0;
         head_q <= 1'b0;
         sec_q  <= '0;
         eot_q  <= '0;
         mt_q   <= 1'b0;
         sk_q   <= 1'b0;
         want_q <= 1'b0;
      end else if (cmd_start) begin
         cyl_q  <= cmd_cyl;
         head_q <= cmd_head;
         sec_q  <= cmd_sec;
         eot_q  <= cmd_eot;
         mt_q   <= cmd_mt;
         sk_q   <= cmd_sk;
         want_q <= cmd_want_del;
      end else if (accept) begin
         cyl_q  <= cyl_n;
         head_q <= head_n;
         sec_q  <= sec_n;
      end
   end

   dss_advance #(
      .CYL_W(CYL_W), .SEC_W(SEC_W), .FIRST_SEC(FIRST_SEC), .MT_ENABLE(MT_ENABLE)
   ) i_advance (
      .cyl_i(cyl_q), .head_i(head_q), .sec_i(sec_q), .eot_i(eot_q), .mt_i(mt_q),
      .cyl_o(cyl_n), .head_o(head_n), .sec_o(sec_n), .track_done_o(track_done)
   );

   dss_judge i_judge (
      .want_del_i(want_q), .mark_del_i(sec_del_mark), .skip_en_i(sk_q),
      .verdict_o(verdict)
   );

   dss_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(cmd_start), .evt_i(sec_evt),
      .verdict_i(verdict), .track_done_i(track_done), .last_i(sec_last),
      .accept_o(accept), .busy_o(busy), .xfer_o(xfer_pulse), .skip_o(skip_pulse),
      .mark_o(ctrl_mark), .done_o(done), .term_o(term)
   );

   assign res_cyl   = cyl_q;
   assign res_head  = head_q;
   assign res_sec   = sec_q;
   assign term_code = term;
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
   parameter int CYL_W = 8,
   parameter int SEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_start,
   input logic             busy,
   input logic             xfer_pulse,
   input logic             skip_pulse,
   input logic             ctrl_mark,
   input logic             done,
   input logic [CYL_W-1:0] res_cyl,
   input logic             res_head,
   input logic [SEC_W-1:0] res_sec,
   input logic [1:0]       term_code
);
   assert_start_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_start) |-> (busy && !ctrl_mark && !done));

   assert_one_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_pulse && skip_pulse));

   assert_mark_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && term_code == 2'd1) |-> ctrl_mark);

   assert_skip_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      skip_pulse |-> ctrl_mark);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> (!xfer_pulse && !skip_pulse && !done));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(busy) && !$past(cmd_start)) |->
         ($stable(res_cyl) && $stable(res_head) && $stable(res_sec)));
endmodule

bind dss_top dss_checker #(.CYL_W(CYL_W), .SEC_W(SEC_W)) i_dss_checker (
   .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .busy(busy),
   .xfer_pulse(xfer_pulse), .skip_pulse(skip_pulse), .ctrl_mark(ctrl_mark),
   .done(done), .res_cyl(res_cyl), .res_head(res_head), .res_sec(res_sec),
   .term_code(term_code)
);

// File: tb/test_dss_top.sv
`timescale 1ns/1ps
module test_dss_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 1'b0;
   logic [7:0] cmd_cyl = '0, cmd_sec = '0, cmd_eot = '0;
   logic       cmd_head = 1'b0, cmd_mt = 1'b0, cmd_sk = 1'b0, cmd_want_del = 1'b0;
   logic       sec_evt = 1'b0, sec_del_mark = 1'b0, sec_last = 1'b0;
   logic       busy, xfer_pulse, skip_pulse, ctrl_mark, done, res_head;
   logic [7:0] res_cyl, res_sec;
   logic [1:0] term_code;

   int n_checks = 0;
   int n_errs = 0;
   bit finished = 1'b0;

   int mc, mh, ms, meot, mterm;
   bit mmt, msk, mwd, mcm, many, mbusy;

   always #2.5 clk = ~clk;

   dss_top i_dss_top (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_cyl(cmd_cyl),
      .cmd_head(cmd_head), .cmd_sec(cmd_sec), .cmd_eot(cmd_eot), .cmd_mt(cmd_mt),
      .cmd_sk(cmd_sk), .cmd_want_del(cmd_want_del), .sec_evt(sec_evt),
      .sec_del_mark(sec_del_mark), .sec_last(sec_last), .busy(busy),
      .xfer_pulse(xfer_pulse), .skip_pulse(skip_pulse), .ctrl_mark(ctrl_mark),
      .done(done), .res_cyl(res_cyl), .res_head(res_head), .res_sec(res_sec),
      .term_code(term_code)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
   endtask

   task automatic start_cmd(input int c, input int h, input int s, input int e,
                            input bit mt, input bit sk, input bit wd);
      @(negedge clk);
      cmd_cyl = c[7:0]; cmd_head = h[0]; cmd_sec = s[7:0]; cmd_eot = e[7:0];
      cmd_mt = mt; cmd_sk = sk; cmd_want_del = wd; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      mc = c; mh = h; ms = s; meot = e; mmt = mt; msk = sk; mwd = wd;
      mcm = 1'b0; many = 1'b0; mbusy = 1'b1;
      chk("R1", "busy", int'(busy), 1);
      chk("R1", "done", int'(done), 0);
      chk("R1", "ctrl_mark", int'(ctrl_mark), 0);
      chk("R1", "cyl", int'(res_cyl), mc);
      chk("R1", "head", int'(res_head), mh);
      chk("R1", "sec", int'(res_sec), ms);
   endtask

   task automatic send_evt(input bit del, input bit last);
      bit    mism, early, skp, endtrk, fin;
      string ptag, dtag, etag;
      mism   = (del != mwd);
      early  = mism && !msk;
      skp    = mism && msk;
      endtrk = (ms == meot) && !(mmt && mh == 0);
      if (ms != meot)   ptag = "R2";
      else if (!mmt)    ptag = "R3";
      else if (mh == 0) ptag = "R4";
      else              ptag = "R5";
      dtag = !mism ? "R6" : (msk ? "R8" : "R7");
      if (mism) mcm = 1'b1;
      if (skp) many = 1'b1;
      if (ms != meot) ms = ms + 1;
      else begin
         ms = 1;
         if (mmt && mh == 0) mh = 1;
         else begin
            mc = (mc + 1) % 256;
            if (mmt) mh = 0;
         end
      end
      fin = early || endtrk || last;
      if (early) mterm = 1; else if (many) mterm = 2; else mterm = 0;
      etag = early ? "R7" : (endtrk ? ptag : (last ? "R9" : ptag));
      @(negedge clk);
      sec_evt = 1'b1; sec_del_mark = del; sec_last = last;
      @(negedge clk);
      sec_evt = 1'b0; sec_last = 1'b0;
      chk(dtag, "xfer_pulse", int'(xfer_pulse), int'(!skp));
      chk(dtag, "skip_pulse", int'(skip_pulse), int'(skp));
      chk(dtag, "ctrl_mark", int'(ctrl_mark), int'(mcm));
      if (!mwd) chk("R11", "xfer on normal read", int'(xfer_pulse), int'(!(del && msk)));
      chk(ptag, "cyl", int'(res_cyl), mc);
      chk(ptag, "head", int'(res_head), mh);
      chk(ptag, "sec", int'(res_sec), ms);
      chk(etag, "done", int'(done), int'(fin));
      chk(etag, "busy", int'(busy), int'(!fin));
      if (fin) chk(many && !early ? "R8" : "R9", "term_code", int'(term_code), mterm);
      mbusy = !fin;
   endtask

   task automatic idle_evt(input bit del);
      @(negedge clk);
      sec_evt = 1'b1; sec_del_mark = del; sec_last = 1'b0;
      @(negedge clk);
      sec_evt = 1'b0;
      chk("R10", "xfer_pulse idle", int'(xfer_pulse), 0);
      chk("R10", "skip_pulse idle", int'(skip_pulse), 0);
      chk("R10", "done idle", int'(done), 0);
      chk("R10", "busy idle", int'(busy), 0);
      chk("R10", "cyl idle", int'(res_cyl), mc);
      chk("R10", "head idle", int'(res_head), mh);
      chk("R10", "sec idle", int'(res_sec), ms);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R12", "busy", int'(busy), 0);
      chk("R12", "done", int'(done), 0);
      chk("R12", "xfer_pulse", int'(xfer_pulse), 0);
      chk("R12", "skip_pulse", int'(skip_pulse), 0);
      chk("R12", "ctrl_mark", int'(ctrl_mark), 0);
      chk("R12", "term_code", int'(term_code), 0);
      chk("R12", "position", int'(res_cyl) + int'(res_head) + int'(res_sec), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mc = 0; mh = 0; ms = 0;
      idle_evt(1'b1);

      for (int wd = 0; wd < 2; wd++)
         for (int sk = 0; sk < 2; sk++)
            for (int mt = 0; mt < 2; mt++)
               for (int h = 0; h < 2; h++)
                  for (int e = 1; e <= 5; e++)
                     for (int s = 1; s <= e; s++) begin
                        int c;
                        int k;
                        c = (s == e) ? 255 : e * 17 + s;
                        start_cmd(c, h, s, e, mt[0], sk[0], wd[0]);
                        k = 0;
                        while (mbusy && k < 12) begin
                           bit d;
                           d = (((k + s + e) % 3) == 0) ? !wd[0] : wd[0];
                           send_evt(d, (e == 5 && k == 4));
                           k++;
                        end
                        if (!mbusy) idle_evt(k[0]);
                     end

      finished = 1'b1;
      report();
      $finish;
   end
endmodule